// File: doc/BRIEF.md
# Single-Port-RAM Synchronous FIFO

This block is a single-clock first-in first-out queue whose storage is a single-port RAM. In any cycle that RAM does one read or one write, and never both. An access arbiter in front of the RAM takes push requests from a producer and pop requests from a consumer. Both sides run on the same clock as the RAM. When the two requests collide, the read gets the port. The push data is parked in a one-entry holding register and is written to the RAM on the next cycle in which the port is free. No push is lost because of a collision.

Read data comes back a fixed two clock edges after an accepted pop, together with a valid strobe. The occupancy count and the full and empty flags include the parked entry. If the only data in the queue sits in the holding register, a pop takes it from there with the same two-edge timing. The block suits sparse traffic, for example one pop and two or three pushes spread over about fourteen cycles. It refuses a push only in two cases: the queue is full, or the holding register is occupied while a read owns the port.

Top module: `spram_fifo`

## Requirements
- R1: A synchronous active-high reset leaves `empty`=1, `full`=0, `count`=0, `rd_valid`=0 and `push_err`=0.
- R2: The RAM never sees a read and a write in the same cycle.
- R3: When a pop and a push are both accepted in one cycle while the RAM holds data, the read is served, and the pushed word is kept and later popped in its place in the order.
- R4: A parked word is written to the RAM on the next free port cycle, ahead of any newer push, so pop order equals accepted push order.
- R5: `rd_valid` is 1 exactly two rising edges after a cycle with `pop`=1 and `empty`=0, and `rd_data` then carries the oldest word.
- R6: A pop when the RAM is empty but the holding register has data returns that word with the same two-edge latency.
- R7: `push_ready` is 0 when `count` equals DEPTH. It is also 0 when the holding register is occupied and a RAM read is granted in the current cycle (`pop`=1 with data in the RAM). Otherwise it is 1.
- R8: A push while `push_ready`=0 is ignored (count and contents unchanged), and `push_err` is 1 for the cycle after it.
- R9: `count` equals RAM entries plus the parked entry and never exceeds DEPTH. `full` is 1 exactly when `count`=DEPTH. `empty` is 1 exactly when `count`=0.
- R10: A pop while `empty`=1 is ignored and produces no `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by producer, consumer and RAM |
| rst | input | 1 | Synchronous active-high reset |
| push | input | 1 | Producer write request |
| push_data | input | WIDTH | Word to enqueue |
| push_ready | output | 1 | Push will be accepted this cycle |
| pop | input | 1 | Consumer read request |
| rd_data | output | WIDTH | Dequeued word |
| rd_valid | output | 1 | `rd_data` is valid |
| count | output | $clog2(DEPTH)+1 | Stored words including the parked one |
| full | output | 1 | Queue holds DEPTH words |
| empty | output | 1 | Queue holds no word |
| push_err | output | 1 | A refused push was made in the previous cycle |

## Verification
Isolated pushes check the plain write path, where the holding register is never used. Pushes that coincide with pops on a non-empty RAM force the park-and-commit path. A second pop right after a collision separates the refusal case from forwarding: with RAM data the push is refused, and with only the parked word the pop is served by forwarding. Filling to DEPTH and pushing again exercises the full refusal. A pop on an empty queue, sparse traffic of the expected kind and long random traffic are all compared each cycle against a queue-based model for data order, flags and the ready signal.

// File: rtl/spf_pkg.sv
package spf_pkg;

    // Fixed RAM read latency in clock edges (output register plus RAM register).
    localparam int RD_LATENCY = 2;

    // One cycle of port decisions produced by the arbiter.
    typedef struct packed {
        logic rd;        // RAM read at the read pointer
        logic wr;        // RAM write at the write pointer
        logic wr_parked; // write source is the holding register
        logic fwd;       // pop served from the holding register
    } port_op_t;

    function automatic logic is_zero(input logic [31:0] v);
        return v == 32'd0;
    endfunction

endpackage

// File: rtl/spf_arbiter.sv
module spf_arbiter
    import spf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       push,
    input  logic                       pop,
    input  logic [$clog2(DEPTH):0]     ram_cnt,
    input  logic                       park_v,
    output port_op_t                   op,
    output logic                       push_ready,
    output logic                       push_ok,
    output logic                       park_load,
    output logic                       park_drain
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic ram_empty;
    logic q_full;
    logic pop_ok;
    logic wr_parked;
    logic wr_new;

    always_comb begin
        ram_empty  = is_zero(32'(ram_cnt));
        q_full     = (ram_cnt + CW'(park_v)) == CW'(DEPTH);
        pop_ok     = pop && !(ram_empty && !park_v);
        op.rd      = pop_ok && !ram_empty;
        op.fwd     = pop_ok && ram_empty;
        // Reads win the port; a parked word blocks a second deferral.
        push_ready = !q_full && !(op.rd && park_v);
        push_ok    = push && push_ready;
        wr_parked  = !op.rd && park_v && !op.fwd;
        wr_new     = !op.rd && (!park_v || op.fwd) && push_ok;
        op.wr        = wr_parked || wr_new;
        op.wr_parked = wr_parked;
        park_load  = push_ok && (op.rd || wr_parked);
        park_drain = wr_parked || op.fwd;
    end

endmodule

// File: rtl/spf_ram.sv
module spf_ram
    import spf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  port_op_t                   op,
    input  logic [$clog2(DEPTH)-1:0]   addr,
    input  logic [WIDTH-1:0]           wr_data,
    input  logic [WIDTH-1:0]           fwd_data,
    output logic [WIDTH-1:0]           rd_data,
    output logic                       rd_valid
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [WIDTH-1:0] stage_d;
    logic             stage_v;

    // Single port: one access per edge.
    always_ff @(posedge clk) begin
        if (op.wr) begin
            mem[addr] <= wr_data;
        end
        if (op.rd) begin
            stage_d <= mem[addr];
        end else if (op.fwd) begin
            stage_d <= fwd_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_v  <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            stage_v  <= op.rd || op.fwd;
            rd_valid <= stage_v;
            rd_data  <= stage_d;
        end
    end

    // R2
    single_port_chk: assert property (@(posedge clk) disable iff (rst)
        !(op.rd && op.wr));

endmodule

// File: rtl/spram_fifo.sv
module spram_fifo
    import spf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [WIDTH-1:0]           push_data,
    output logic                       push_ready,
    input  logic                       pop,
    output logic [WIDTH-1:0]           rd_data,
    output logic                       rd_valid,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       full,
    output logic                       empty,
    output logic                       push_err
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [AW:0]      wr_ptr;
    logic [AW:0]      rd_ptr;
    logic [CW-1:0]    ram_cnt;
    logic             park_v;
    logic [WIDTH-1:0] park_d;
    port_op_t         op;
    logic             push_ok;
    logic             park_load;
    logic             park_drain;
    logic [AW-1:0]    addr;
    logic [WIDTH-1:0] wr_data;

    assign ram_cnt = wr_ptr - rd_ptr;
    assign count   = ram_cnt + CW'(park_v);
    assign full    = count == CW'(DEPTH);
    assign empty   = count == '0;
    assign addr    = op.rd ? rd_ptr[AW-1:0] : wr_ptr[AW-1:0];
    assign wr_data = op.wr_parked ? park_d : push_data;

    spf_arbiter #(.DEPTH(DEPTH)) arb_i (
        .push       (push),
        .pop        (pop),
        .ram_cnt    (ram_cnt),
        .park_v     (park_v),
        .op         (op),
        .push_ready (push_ready),
        .push_ok    (push_ok),
        .park_load  (park_load),
        .park_drain (park_drain)
    );

    spf_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) ram_i (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .addr     (addr),
        .wr_data  (wr_data),
        .fwd_data (park_d),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            park_v   <= 1'b0;
            park_d   <= '0;
            push_err <= 1'b0;
        end else begin
            if (op.wr) wr_ptr <= wr_ptr + 1'b1;
            if (op.rd) rd_ptr <= rd_ptr + 1'b1;
            if (park_load) begin
                park_v <= 1'b1;
                park_d <= push_data;
            end else if (park_drain) begin
                park_v <= 1'b0;
            end
            push_err <= push && !push_ready;
        end
    end

    // R9
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R8
    push_err_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !push_ready) |=> push_err);

    // R8
    refused_push_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !push_ready && !pop) |=> (count == $past(count)));

    // R7
    full_refuse_chk: assert property (@(posedge clk) disable iff (rst)
        full |-> !push_ready);

    // R5
    rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
        $past(pop && !empty, 2) |-> rd_valid);

    // R10
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(pop && !empty, 2));

    // R4
    park_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (park_v && !pop) |=> (wr_ptr == $past(wr_ptr) + 1'b1));

endmodule

// File: tb/spram_fifo_tb.sv
`timescale 1ns/1ps
module spram_fifo_tb_top;
    localparam int DEPTH = 16;
    localparam int WIDTH = 8;
    localparam int CW    = $clog2(DEPTH) + 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             push = 1'b0;
    logic [WIDTH-1:0] push_data = '0;
    logic             pop = 1'b0;
    logic             push_ready;
    logic [WIDTH-1:0] rd_data;
    logic             rd_valid;
    logic [CW-1:0]    count;
    logic             full;
    logic             empty;
    logic             push_err;

    always #4 clk = ~clk;

    spram_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (
        .clk(clk), .rst(rst), .push(push), .push_data(push_data),
        .push_ready(push_ready), .pop(pop), .rd_data(rd_data),
        .rd_valid(rd_valid), .count(count), .full(full), .empty(empty),
        .push_err(push_err)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Behavioural reference: queue of words, RAM-resident count, parked flag.
    logic [WIDTH-1:0] q[$];
    int               ram_n = 0;
    bit               parked = 0;
    bit               v1 = 0, v2 = 0;
    logic [WIDTH-1:0] d1 = '0, d2 = '0;
    bit               err_exp = 0;
    string            tag = "R5";

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, check ready, update model at posedge,
    // compare registered outputs at the following negedge.
    task automatic step(input bit ps, input logic [WIDTH-1:0] d, input bit pp);
        bit pop_ok, rd, fwd, ready, push_ok;
        push = ps; push_data = d; pop = pp;
        #1;
        pop_ok  = pp && (q.size() > 0);
        rd      = pop_ok && (ram_n > 0);
        fwd     = pop_ok && (ram_n == 0);
        ready   = (q.size() < DEPTH) && !(rd && parked);
        push_ok = ps && ready;
        chk("R7 push_ready", push_ready, ready);
        @(posedge clk);
        v2 = v1; d2 = d1;
        v1 = pop_ok;
        if (pop_ok) d1 = q.pop_front();
        if (push_ok) q.push_back(d);
        if (rd) begin
            ram_n--;
            if (push_ok) parked = 1;
        end else if (fwd) begin
            parked = 0;
            if (push_ok) ram_n++;
        end else if (parked) begin
            ram_n++;
            parked = push_ok;
        end else if (push_ok) begin
            ram_n++;
        end
        err_exp = ps && !ready;
        @(negedge clk);
        push = 0; pop = 0;
        chk("R5 R10 rd_valid", rd_valid, v2);
        if (v2) chk({tag, " R4 rd_data"}, rd_data, d2);
        chk("R9 count", count, q.size());
        chk("R9 full", full, q.size() == DEPTH);
        chk("R9 empty", empty, q.size() == 0);
        chk("R8 push_err", push_err, err_exp);
    endtask

    initial begin
        #150000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1 empty", empty, 1);
        chk("R1 full", full, 0);
        chk("R1 count", count, 0);
        chk("R1 rd_valid", rd_valid, 0);
        chk("R1 push_err", push_err, 0);

        // R10 pop on empty queue
        step(0, 0, 1); step(0, 0, 0); step(0, 0, 0);

        // Isolated pushes, then isolated pops
        step(1, 8'h11, 0); step(0, 0, 0); step(1, 8'h22, 0); step(0, 0, 0);
        step(0, 0, 1); step(0, 0, 0); step(0, 0, 0);
        step(0, 0, 1); step(0, 0, 0); step(0, 0, 0);

        // R3 collision parks the push; then R6 forwarding from the parked word
        tag = "R3";
        step(1, 8'hA1, 0);
        step(1, 8'hB2, 1);
        tag = "R6";
        step(0, 0, 1);
        step(0, 0, 0); step(0, 0, 0);
        tag = "R5";

        // R7 refusal: parked word plus a granted read, then R4 commit order
        step(1, 8'h31, 0); step(1, 8'h32, 0);
        step(1, 8'h33, 1);
        step(1, 8'h34, 1);
        step(1, 8'h35, 0);
        step(0, 0, 0);
        repeat (4) begin step(0, 0, 1); step(0, 0, 0); end
        step(0, 0, 0); step(0, 0, 0);

        // R9 fill to DEPTH, then R8 push at full
        for (int i = 0; i < DEPTH; i++) step(1, 8'(8'h40 + i), 0);
        step(1, 8'hEE, 0);
        step(0, 0, 0);
        for (int i = 0; i < DEPTH; i++) step(0, 0, 1);
        step(0, 0, 0); step(0, 0, 0);

        // Sparse traffic: one pop and up to three pushes per 14 cycles
        for (int w = 0; w < 20; w++) begin
            for (int c = 0; c < 14; c++) begin
                step(c == 1 || c == 5 || (c == 9 && w[0]), 8'(w * 7 + c), c == 5);
            end
        end
        while (q.size() > 0) step(0, 0, 1);
        step(0, 0, 0); step(0, 0, 0);

        // Random traffic
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 3) != 0, 8'($urandom), ($urandom % 2) == 0);
        end
        step(0, 0, 0); step(0, 0, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule